// File: doc/BRIEF.md
# Interrupt sampling and vectoring controller

This block decides when an 8051-class core takes a hardware call into an interrupt service routine, and to which address. On every machine-cycle strobe it captures the interrupt flags. It then evaluates the capture from the previous strobe. Among the sources that are pending and enabled, it picks the one with the highest priority level and raises a call request with that source's vector address. The request stays up until the core acknowledges it.

The core reports three things about the instruction in progress: whether the current cycle is its final cycle, whether it is a return-from-interrupt, and whether it writes an enable or priority register. Any of these can suppress the call for that cycle. Nothing is stored for a call that was suppressed, so the next poll starts from the new capture.

The two highest vector slots are each shared between two sources. A per-slot select bit decides which source owns the slot. Hardware clears a flag only for external-pin sources, and the clear is delivered as a one-cycle strobe when the call is acknowledged.

Top module: `irq_vector_ctl`

## Requirements
- R1: A flag present at machine-cycle strobe k is polled at strobe k+1, so `call_req` rises after the second strobe and not after the first.
- R2: The level of source i is {prio_hi[i], prio_lo[i]}, from 0 (lowest) to 3. The highest level wins. Within one level, the lowest source index wins.
- R3: The call is suppressed while any level equal to or above the candidate's level is in service. A strictly higher level is still called. A level enters service when its call is acknowledged.
- R4: No call is raised in a poll where `last_cyc` is low.
- R5: No call is raised in a poll where `is_reti` or `is_ctl_wr` is high. A RETI in a final cycle takes the highest level out of service.
- R6: A suppressed request is not remembered. If the flag has dropped by the time the block ends, no call follows.
- R7: Slot 6 (vector 0x33) takes its flag from `alt_flag[0]` when `alt_sel[0]` is 1. In that case `flag_clr[6]` stays low on acknowledge. When `alt_sel[0]` is 0, the slot takes `irq_flag[6]`, is gated by `src_en[6]`, and pulses `flag_clr[6]` on acknowledge.
- R8: Slot 7 (vector 0x3B) behaves the same way, using `alt_sel[1]`, `alt_flag[1]`, `irq_flag[7]`, `src_en[7]` and `flag_clr[7]`.
- R9: The serial slot 4 (vector 0x23) is never cleared by hardware.
- R10: `vec_addr` is 0x03 + 8 × index. `call_req` and `vec_addr` hold steady until `call_ack`. After an acknowledge, `call_req` drops on the next edge and `flag_clr` pulses for exactly one cycle.
- R11: When `glb_en` is low, no call is raised.
- R12: After reset, `call_req` is 0, `flag_clr` is 0 and no level is in service.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| mc_tick | input | 1 | Machine-cycle strobe: sample and poll |
| glb_en | input | 1 | Global interrupt enable |
| src_en | input | NSRC | Per-source enables |
| prio_lo | input | NSRC | Priority level, low bit |
| prio_hi | input | NSRC | Priority level, high bit |
| irq_flag | input | NSRC | Interrupt flags |
| alt_flag | input | NSH | Flags of the alternate owners of the shared slots |
| alt_sel | input | NSH | Gives a shared slot to its alternate owner (also acts as its enable) |
| last_cyc | input | 1 | Current cycle is the final cycle of the instruction |
| is_reti | input | 1 | Instruction in progress is RETI |
| is_ctl_wr | input | 1 | Instruction writes an enable or priority register |
| call_ack | input | 1 | Core accepts the call |
| call_req | output | 1 | Hardware call request |
| vec_addr | output | AW | Vector address |
| flag_clr | output | NSRC | One-cycle flag clear strobes |

## Verification
The bench checks that the first strobe after a flag appears only samples it. A design that polled the live flag would call one machine cycle early.

It sets equal-level and higher-level requests against an active level. A wrong in-service comparison would either nest a call at the same level or block a legitimate preemption.

It drops a flag while the call is suppressed by a non-final cycle. A design that latched refused requests would then call anyway.

For both shared slots it swaps the owner. A wrong mux would clear the pin flag when the alternate source was serviced, or would take the vector from the wrong flag.

// File: rtl/irqc_pkg.sv
package irqc_pkg;
    localparam int unsigned NLVL = 4;
    typedef logic [1:0] lvl_t;

    function automatic logic [7:0] vec_of(input int unsigned idx, input int unsigned base,
                                          input int unsigned step);
        return 8'(base + step * idx);
    endfunction
endpackage

// File: rtl/irqc_src_mux.sv
module irqc_src_mux #(
    parameter int unsigned NSRC     = 8,
    parameter int unsigned NSH      = 2,
    parameter logic [NSRC-1:0] PIN_MASK = 8'b1100_0101
) (
    input  logic [NSRC-1:0] irq_flag,
    input  logic [NSH-1:0]  alt_flag,
    input  logic [NSH-1:0]  alt_sel,
    input  logic [NSRC-1:0] src_en,
    output logic [NSRC-1:0] eff_flag,
    output logic [NSRC-1:0] eff_en,
    output logic [NSRC-1:0] clr_ok
);
    localparam int unsigned SH_BASE = NSRC - NSH;

    for (genvar i = 0; i < NSRC; i++) begin : g_slot
        if (i >= SH_BASE) begin : g_shared
            assign eff_flag[i] = alt_sel[i-SH_BASE] ? alt_flag[i-SH_BASE] : irq_flag[i];
            assign eff_en[i]   = alt_sel[i-SH_BASE] | src_en[i];
            assign clr_ok[i]   = PIN_MASK[i] & ~alt_sel[i-SH_BASE];
        end else begin : g_plain
            assign eff_flag[i] = irq_flag[i];
            assign eff_en[i]   = src_en[i];
            assign clr_ok[i]   = PIN_MASK[i];
        end
    end
endmodule

// File: rtl/irqc_arbiter.sv
module irqc_arbiter #(
    parameter int unsigned NSRC = 8,
    localparam int unsigned IW  = $clog2(NSRC)
) (
    input  logic [NSRC-1:0]   pend,
    input  logic [NSRC-1:0]   prio_lo,
    input  logic [NSRC-1:0]   prio_hi,
    output logic              found,
    output logic [IW-1:0]     win_idx,
    output irqc_pkg::lvl_t    win_lvl
);
    always_comb begin
        found   = 1'b0;
        win_idx = '0;
        win_lvl = '0;
        for (int i = 0; i < NSRC; i++) begin
            if (pend[i] && (!found || {prio_hi[i], prio_lo[i]} > win_lvl)) begin
                found   = 1'b1;
                win_idx = IW'(i);
                win_lvl = {prio_hi[i], prio_lo[i]};
            end
        end
    end
endmodule

// File: rtl/irq_vector_ctl.sv
module irq_vector_ctl #(
    parameter int unsigned NSRC     = 8,
    parameter int unsigned NSH      = 2,
    parameter int unsigned AW       = 8,
    parameter int unsigned VEC_BASE = 3,
    parameter int unsigned VEC_STEP = 8,
    parameter logic [NSRC-1:0] PIN_MASK = 8'b1100_0101
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            mc_tick,
    input  logic            glb_en,
    input  logic [NSRC-1:0] src_en,
    input  logic [NSRC-1:0] prio_lo,
    input  logic [NSRC-1:0] prio_hi,
    input  logic [NSRC-1:0] irq_flag,
    input  logic [NSH-1:0]  alt_flag,
    input  logic [NSH-1:0]  alt_sel,
    input  logic            last_cyc,
    input  logic            is_reti,
    input  logic            is_ctl_wr,
    input  logic            call_ack,
    output logic            call_req,
    output logic [AW-1:0]   vec_addr,
    output logic [NSRC-1:0] flag_clr
);
    localparam int unsigned IW = $clog2(NSRC);
    localparam int unsigned NL = irqc_pkg::NLVL;

    typedef struct packed {
        logic [NSRC-1:0] samp;
        logic            call;
        logic [IW-1:0]   idx;
        irqc_pkg::lvl_t  lvl;
        logic            clr_ok;
        logic [NL-1:0]   isv;
        logic [NSRC-1:0] clr;
    } state_t;

    state_t s_d, s_q;

    logic [NSRC-1:0] eff_flag, eff_en, clr_ok;
    logic            found;
    logic [IW-1:0]   win_idx;
    irqc_pkg::lvl_t  win_lvl;

    irqc_src_mux #(.NSRC(NSRC), .NSH(NSH), .PIN_MASK(PIN_MASK)) mux_i (
        .irq_flag(irq_flag), .alt_flag(alt_flag), .alt_sel(alt_sel), .src_en(src_en),
        .eff_flag(eff_flag), .eff_en(eff_en), .clr_ok(clr_ok)
    );

    irqc_arbiter #(.NSRC(NSRC)) arb_i (
        .pend(s_q.samp & eff_en & {NSRC{glb_en}}),
        .prio_lo(prio_lo), .prio_hi(prio_hi),
        .found(found), .win_idx(win_idx), .win_lvl(win_lvl)
    );

    logic isv_block;
    always_comb begin
        isv_block = 1'b0;
        for (int l = 0; l < NL; l++) begin
            if (s_q.isv[l] && l >= int'(win_lvl)) isv_block = 1'b1;
        end
    end

    always_comb begin
        s_d     = s_q;
        s_d.clr = '0;
        if (s_q.call && call_ack) begin
            s_d.call           = 1'b0;
            s_d.isv[s_q.lvl]   = 1'b1;
            s_d.clr[s_q.idx]   = s_q.clr_ok;
        end
        if (mc_tick) begin
            s_d.samp = eff_flag;
            if (is_reti && last_cyc) begin
                for (int l = 0; l < NL; l++) begin
                    if (s_q.isv[l] && (s_q.isv >> (l + 1)) == '0) s_d.isv[l] = 1'b0;
                end
            end
            if (!s_q.call && found && !isv_block && last_cyc && !is_reti && !is_ctl_wr) begin
                s_d.call   = 1'b1;
                s_d.idx    = win_idx;
                s_d.lvl    = win_lvl;
                s_d.clr_ok = clr_ok[win_idx];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign call_req = s_q.call;
    assign vec_addr = AW'(VEC_BASE + VEC_STEP * int'(s_q.idx));
    assign flag_clr = s_q.clr;
endmodule

// File: rtl/irq_vector_ctl_chk.sv
module irq_vector_ctl_chk #(
    parameter int unsigned NSRC = 8,
    parameter int unsigned AW   = 8
) (
    input logic            clk,
    input logic            rst_n,
    input logic            glb_en,
    input logic            last_cyc,
    input logic            is_reti,
    input logic            is_ctl_wr,
    input logic            call_ack,
    input logic            call_req,
    input logic [AW-1:0]   vec_addr,
    input logic [NSRC-1:0] flag_clr
);
    a_r10_hold_until_ack: assert property (@(posedge clk) disable iff (!rst_n)
        call_req && !call_ack |=> call_req && $stable(vec_addr));

    a_r10_drop_on_ack: assert property (@(posedge clk) disable iff (!rst_n)
        call_req && call_ack |=> !call_req);

    a_r10_clr_after_ack: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_clr != '0) |-> $past(call_req && call_ack));

    a_r10_clr_onehot: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(flag_clr));

    a_r5_call_gated: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(call_req) |-> $past(last_cyc && !is_reti && !is_ctl_wr && glb_en));

    a_r9_serial_no_clr: assert property (@(posedge clk) disable iff (!rst_n)
        !flag_clr[4]);
endmodule

bind irq_vector_ctl irq_vector_ctl_chk #(.NSRC(NSRC), .AW(AW)) chk_i (
    .clk(clk), .rst_n(rst_n), .glb_en(glb_en), .last_cyc(last_cyc), .is_reti(is_reti),
    .is_ctl_wr(is_ctl_wr), .call_ack(call_ack), .call_req(call_req),
    .vec_addr(vec_addr), .flag_clr(flag_clr)
);

// File: tb/irq_vector_ctl_tb.sv
module irq_vector_ctl_tb_top;
    logic clk = 1'b0, rst_n = 1'b0;
    logic mc_tick, glb_en, last_cyc, is_reti, is_ctl_wr, call_ack;
    logic [7:0] src_en, prio_lo, prio_hi, irq_flag, flag_clr, vec_addr;
    logic [1:0] alt_flag, alt_sel;
    logic call_req;
    int n_run = 0, n_fail = 0;

    always #4 clk = ~clk;

    irq_vector_ctl dut_i (
        .clk(clk), .rst_n(rst_n), .mc_tick(mc_tick), .glb_en(glb_en), .src_en(src_en),
        .prio_lo(prio_lo), .prio_hi(prio_hi), .irq_flag(irq_flag), .alt_flag(alt_flag),
        .alt_sel(alt_sel), .last_cyc(last_cyc), .is_reti(is_reti), .is_ctl_wr(is_ctl_wr),
        .call_ack(call_ack), .call_req(call_req), .vec_addr(vec_addr), .flag_clr(flag_clr)
    );

    task automatic check(input string req, input int act, input int exp);
        n_run++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic step(input int n);
        repeat (n) begin
            @(posedge clk);
            @(negedge clk);
        end
    endtask

    task automatic do_reset();
        rst_n = 1'b0; mc_tick = 1'b1; glb_en = 1'b1; last_cyc = 1'b1; is_reti = 1'b0;
        is_ctl_wr = 1'b0; call_ack = 1'b0; src_en = '1; prio_lo = '0; prio_hi = '0;
        irq_flag = '0; alt_flag = '0; alt_sel = '0;
        step(2);
        rst_n = 1'b1;
        step(1);
    endtask

    // acknowledge a pending call; return clear strobe seen
    task automatic ack(output logic [7:0] clr);
        call_ack = 1'b1;
        step(1);
        call_ack = 1'b0;
        clr = flag_clr;
    endtask

    task automatic t_reset();
        do_reset();
        check("R12 call_req", int'(call_req), 0);
        check("R12 flag_clr", int'(flag_clr), 0);
    endtask

    task automatic t_sample_poll();
        do_reset();
        irq_flag[1] = 1'b1;
        step(1);
        check("R1 not after first strobe", int'(call_req), 0);
        step(1);
        check("R1 call after second strobe", int'(call_req), 1);
        check("R10 vector 0x0B", int'(vec_addr), 'h0B);
    endtask

    task automatic t_priority();
        logic [7:0] c;
        do_reset();
        irq_flag = 8'b0010_1010;
        step(2);
        check("R2 tie lowest index", int'(vec_addr), 'h0B);
        do_reset();
        irq_flag = 8'b0010_1010; prio_hi[5] = 1'b1;
        step(2);
        check("R2 higher level wins", int'(vec_addr), 'h2B);
        do_reset();
        irq_flag = 8'b0010_1010; prio_hi[5] = 1'b1; prio_hi[3] = 1'b1; prio_lo[3] = 1'b1;
        step(2);
        check("R2 level 3 wins", int'(vec_addr), 'h1B);
        ack(c);
    endtask

    task automatic t_in_service();
        logic [7:0] c;
        do_reset();
        irq_flag[0] = 1'b1;
        step(2);
        ack(c);
        check("R10 drop after ack", int'(call_req), 0);
        check("R10 pin clear strobe", int'(c), 'h01);
        step(1);
        check("R10 strobe one cycle", int'(flag_clr), 0);
        irq_flag = 8'b0000_0010;
        step(4);
        check("R3 equal level blocked", int'(call_req), 0);
        prio_lo[1] = 1'b1;
        step(1);
        check("R3 higher level called", int'(call_req), 1);
        check("R3 vector", int'(vec_addr), 'h0B);
    endtask

    task automatic t_reti();
        logic [7:0] c;
        do_reset();
        irq_flag[0] = 1'b1;
        step(2);
        ack(c);
        irq_flag = 8'b0000_0100;
        step(3);
        check("R3 blocked before reti", int'(call_req), 0);
        is_reti = 1'b1;
        step(1);
        is_reti = 1'b0;
        check("R5 no call in reti cycle", int'(call_req), 0);
        step(1);
        check("R5 call after reti", int'(call_req), 1);
        check("R5 vector 0x13", int'(vec_addr), 'h13);
    endtask

    task automatic t_ctl_wr_last();
        do_reset();
        is_ctl_wr = 1'b1; irq_flag[3] = 1'b1;
        step(4);
        check("R5 ctl write blocks", int'(call_req), 0);
        is_ctl_wr = 1'b0;
        step(1);
        check("R5 call after ctl write", int'(call_req), 1);
        do_reset();
        last_cyc = 1'b0; irq_flag[3] = 1'b1;
        step(4);
        check("R4 not final cycle blocks", int'(call_req), 0);
        last_cyc = 1'b1;
        step(1);
        check("R4 call at final cycle", int'(call_req), 1);
    endtask

    task automatic t_no_memory();
        do_reset();
        last_cyc = 1'b0; irq_flag[2] = 1'b1;
        step(3);
        irq_flag[2] = 1'b0;
        step(1);
        last_cyc = 1'b1;
        step(3);
        check("R6 refused request forgotten", int'(call_req), 0);
    endtask

    task automatic t_shared();
        logic [7:0] c;
        do_reset();
        alt_sel = 2'b01; src_en[6] = 1'b0; alt_flag[0] = 1'b1; irq_flag[6] = 1'b1;
        step(2);
        check("R7 comparator vector", int'(vec_addr), 'h33);
        ack(c);
        check("R7 pin flag kept", int'(c), 0);
        do_reset();
        alt_flag[0] = 1'b1;
        step(3);
        check("R7 alt flag ignored when unselected", int'(call_req), 0);
        irq_flag[6] = 1'b1;
        step(2);
        check("R7 pin vector", int'(vec_addr), 'h33);
        ack(c);
        check("R7 pin flag cleared", int'(c), 'h40);
        do_reset();
        alt_sel = 2'b10; src_en[7] = 1'b0; alt_flag[1] = 1'b1;
        step(2);
        check("R8 pwm vector", int'(vec_addr), 'h3B);
        ack(c);
        check("R8 pin flag kept", int'(c), 0);
        do_reset();
        irq_flag[7] = 1'b1;
        step(2);
        check("R8 pin vector", int'(vec_addr), 'h3B);
        ack(c);
        check("R8 pin flag cleared", int'(c), 'h80);
        do_reset();
        src_en[7] = 1'b0; irq_flag[7] = 1'b1;
        step(3);
        check("R8 disabled pin ignored", int'(call_req), 0);
    endtask

    task automatic t_serial_hold_gate();
        logic [7:0] c;
        do_reset();
        irq_flag[4] = 1'b1;
        step(2);
        check("R10 vector 0x23", int'(vec_addr), 'h23);
        irq_flag = '0;
        step(5);
        check("R10 held until ack", int'(call_req), 1);
        check("R10 vector stable", int'(vec_addr), 'h23);
        ack(c);
        check("R9 serial not cleared", int'(c), 0);
        do_reset();
        glb_en = 1'b0; irq_flag = '1;
        step(4);
        check("R11 global disable", int'(call_req), 0);
    endtask

    initial begin
        fork
            begin
                t_reset();
                t_sample_poll();
                t_priority();
                t_in_service();
                t_reti();
                t_ctl_wr_last();
                t_no_memory();
                t_shared();
                t_serial_hold_gate();
            end
            begin
                repeat (20000) @(posedge clk);
                n_run++; n_fail++;
                $display("FAIL watchdog: actual timeout expected completion");
            end
        join_any
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule